// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-visible front of a panel display controller. A plain 32-bit register port, with a write strobe and a combinational read path, gives access to six word registers. Those registers hold the controller mode, the panel size, the interrupt enables, one general timing word and one subpanel word. The block presents the decoded mode fields, the panel width and height and the run bit to the pixel fetch engine. It tells that engine, with one-cycle pulses, when software starts or stops the controller.

The fetch engine reports three kinds of event: the palette is loaded, a frame has finished, and a sync error has occurred. Each event sets a sticky status flag. A single level interrupt, driven from a register, combines the flags with the interrupt enables. Starting and stopping the controller clears and sets these flags as described below. Reserved bits of several registers read back as ones. The size fields read back as the stored size minus one.

Top module: `dispctl_regs`

## Requirements
- R1: After reset the reads are: control 0xFE000C34, timing0 0x000003FF, timing1 0x000003FF, timing2 0xFC000000, status 0, subpanel 0. The interrupt is low.
- R2: A control write (offset 0x00) captures the run bit (bit 0), mono (bit 1), the two interrupt enables (bits 4:3, frame at bit 3, palette at bit 4), TFT (bit 7) and the load mode (bits 21:20). It keeps bits under mask 0x01CFF300. A read returns those fields in place, TFT also at bit 23, all ORed with 0xFE000C34.
- R3: A timing0 write (0x04) sets the width to bits 9:0 plus one and keeps bits 31:10. A read returns the kept bits, width-1 in bits 9:0, ORed with 0xF. Timing1 (0x08) does the same for the height, without the OR.
- R4: Timing2 (0x0C) is stored whole and reads ORed with 0xFC000000. Subpanel (0x14) stores the written value ANDed with 0xA1FFFFFF.
- R5: Writes to status (0x10) change nothing. Any offset other than the six reads zero and ignores writes.
- R6: A one-cycle event pulse sets its sticky flag. Status reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0.
- R7: One cycle after the flags and enables settle, the interrupt is high when frame-done is set with the frame enable set, or palette-done is set with the palette enable set, or sync-error is set whatever the enables. Otherwise it is low.
- R8: A control write that changes the run bit from 1 to 0 clears sync-error. It sets frame-done unless the written load mode is 1. It gives a one-cycle stop pulse.
- R9: A control write that changes the run bit from 0 to 1 clears frame-done and palette-done and gives a one-cycle start pulse. A write that leaves the run bit unchanged touches no flag.
- R10: An event pulse in the same cycle as a clearing control write wins, and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_i | input | 1 | write strobe |
| addr_i | input | ADDR_W | byte offset of the register |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i, combinational |
| pal_done_i | input | 1 | palette-loaded event pulse |
| frame_done_i | input | 1 | frame-done event pulse |
| sync_err_i | input | 1 | sync-error event pulse |
| en_o | output | 1 | run bit |
| en_rise_o | output | 1 | start pulse, one cycle after the write |
| en_fall_o | output | 1 | stop pulse, one cycle after the write |
| mode_o | output | 2 | load mode |
| tft_o | output | 1 | active-matrix panel select |
| mono_o | output | 1 | monochrome select |
| width_o | output | DIM_W+1 | panel width in pixels |
| height_o | output | DIM_W+1 | panel height in lines |
| irq_o | output | 1 | level interrupt, registered |

## Verification
The control register is written with all ones, with zero and with sparse patterns. This separates the kept-bit mask, the forced-ones mask and the duplicated TFT bit. The size registers are written with a mixed pattern, a maximal low field and a zero low field. These show the plus-one on store and the minus-one on read at both ends of the range. Stop writes are made with load mode 3 and load mode 1, so the frame-done exception is seen. Event pulses are placed in the very cycle of start and stop writes, which shows that a set wins over a clear. The interrupt is walked through each enable alone and through sync-error with both enables off.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_TIM0 = 'h04;
  localparam int unsigned OFS_TIM1 = 'h08;
  localparam int unsigned OFS_TIM2 = 'h0C;
  localparam int unsigned OFS_STAT = 'h10;
  localparam int unsigned OFS_SUBP = 'h14;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h01CF_F300;
  localparam logic [REG_W-1:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [REG_W-1:0] TIM0_ONES = 32'h0000_000F;
  localparam logic [REG_W-1:0] TIM2_ONES = 32'hFC00_0000;
  localparam logic [REG_W-1:0] SUBP_MASK = 32'hA1FF_FFFF;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_MONO   = 1;
  localparam int unsigned B_IE     = 3;
  localparam int unsigned B_TFT    = 7;
  localparam int unsigned B_MODE   = 20;
  localparam int unsigned B_TFT_HI = 23;
  localparam int unsigned B_S_FRM  = 0;
  localparam int unsigned B_S_SYN  = 2;
  localparam int unsigned B_S_PAL  = 6;

  localparam logic [1:0] MODE_PAL_ONLY = 2'd1;

  typedef struct packed {
    logic [1:0] mode;
    logic       tft;
    logic [1:0] ie;    // [0] frame, [1] palette
    logic       mono;
    logic       en;
  } ctrl_t;

  typedef struct packed {
    logic pal;
    logic sync;
    logic frame;
  } stat_t;
endpackage

// File: rtl/dispctl_stat.sv
module dispctl_stat
  import dispctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pal_ev_i,
  input  logic       frame_ev_i,
  input  logic       sync_ev_i,
  input  logic       en_set_i,
  input  logic       en_clr_i,
  input  logic       frame_on_stop_i,
  input  logic [1:0] ie_i,
  output stat_t      stat_o,
  output logic       irq_o
);
  stat_t st_q, st_n;
  logic  irq_q;

  // event sets take priority over start/stop clears
  always_comb begin
    st_n.frame = frame_ev_i | (st_q.frame & ~en_set_i) | (en_clr_i & frame_on_stop_i);
    st_n.pal   = pal_ev_i   | (st_q.pal   & ~en_set_i);
    st_n.sync  = sync_ev_i  | (st_q.sync  & ~en_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      irq_q <= (st_q.frame & ie_i[0]) | (st_q.pal & ie_i[1]) | st_q.sync;
    end
  end

  assign stat_o = st_q;
  assign irq_o  = irq_q;

  p_sync_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.sync |=> irq_o);
  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(st_q.frame && ie_i[0]) && !(st_q.pal && ie_i[1]) && !st_q.sync) |=> !irq_o);
  p_stop_clears_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i && !sync_ev_i) |=> !stat_o.sync);
  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_i && !frame_ev_i && !pal_ev_i) |=> (!stat_o.frame && !stat_o.pal));
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ev_i || pal_ev_i || sync_ev_i) |=>
      ((stat_o.frame || !$past(frame_ev_i)) && (stat_o.pal || !$past(pal_ev_i)) &&
       (stat_o.sync || !$past(sync_ev_i))));
endmodule

// File: rtl/dispctl_cfg.sv
module dispctl_cfg
  import dispctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIM_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  stat_t             stat_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [DIM_W:0]    width_o,
  output logic [DIM_W:0]    height_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic              frame_on_stop_o,
  output logic              en_rise_o,
  output logic              en_fall_o
);
  localparam int unsigned UP_W = REG_W - DIM_W;
  localparam int unsigned SZ_W = DIM_W + 1;

  logic sel_ctrl, sel_tim2, sel_stat, sel_subp;
  logic [1:0] sel_tim;

  assign sel_ctrl   = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_tim[0] = addr_i == ADDR_W'(OFS_TIM0);
  assign sel_tim[1] = addr_i == ADDR_W'(OFS_TIM1);
  assign sel_tim2   = addr_i == ADDR_W'(OFS_TIM2);
  assign sel_stat   = addr_i == ADDR_W'(OFS_STAT);
  assign sel_subp   = addr_i == ADDR_W'(OFS_SUBP);

  ctrl_t            ctrl_q;
  logic [REG_W-1:0] keep_q, tim2_q, subp_q;
  logic             rise_q, fall_q;
  logic [UP_W-1:0]  up_q   [2];
  logic [SZ_W-1:0]  size_q [2];
  logic [REG_W-1:0] tim_rd [2];

  logic wr_ctrl;
  assign wr_ctrl         = wr_i && sel_ctrl;
  assign en_set_o        = wr_ctrl &&  wdata_i[B_EN] && !ctrl_q.en;
  assign en_clr_o        = wr_ctrl && !wdata_i[B_EN] &&  ctrl_q.en;
  assign frame_on_stop_o = wdata_i[B_MODE+1:B_MODE] != MODE_PAL_ONLY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      keep_q <= '0;
      tim2_q <= '0;
      subp_q <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= en_set_o;
      fall_q <= en_clr_o;
      if (wr_ctrl) begin
        ctrl_q.mode <= wdata_i[B_MODE+1:B_MODE];
        ctrl_q.tft  <= wdata_i[B_TFT];
        ctrl_q.ie   <= wdata_i[B_IE+1:B_IE];
        ctrl_q.mono <= wdata_i[B_MONO];
        ctrl_q.en   <= wdata_i[B_EN];
        keep_q      <= wdata_i & CTRL_KEEP;
      end
      if (wr_i && sel_tim2) tim2_q <= wdata_i;
      if (wr_i && sel_subp) subp_q <= wdata_i & SUBP_MASK;
    end
  end

  // timing0 / timing1: stored size is field + 1, read back as size - 1
  for (genvar g = 0; g < 2; g++) begin : g_dim
    logic [SZ_W-1:0] size_m1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[g]   <= '0;
        size_q[g] <= '0;
      end else if (wr_i && sel_tim[g]) begin
        up_q[g]   <= wdata_i[REG_W-1:DIM_W];
        size_q[g] <= SZ_W'(wdata_i[DIM_W-1:0]) + SZ_W'(1);
      end
    end
    assign size_m1   = size_q[g] - SZ_W'(1);
    assign tim_rd[g] = {up_q[g], size_m1[DIM_W-1:0]} | ((g == 0) ? TIM0_ONES : '0);
  end

  logic [REG_W-1:0] ctrl_rd, stat_rd;
  always_comb begin
    ctrl_rd = CTRL_ONES | keep_q;
    ctrl_rd[B_TFT_HI]          = ctrl_q.tft;
    ctrl_rd[B_MODE+1:B_MODE]   = ctrl_q.mode;
    ctrl_rd[B_TFT]             = ctrl_q.tft;
    ctrl_rd[B_IE+1:B_IE]       = ctrl_q.ie;
    ctrl_rd[B_MONO]            = ctrl_q.mono;
    ctrl_rd[B_EN]              = ctrl_q.en;
    ctrl_rd = ctrl_rd | CTRL_ONES | keep_q;
    stat_rd          = '0;
    stat_rd[B_S_PAL] = stat_i.pal;
    stat_rd[B_S_SYN] = stat_i.sync;
    stat_rd[B_S_FRM] = stat_i.frame;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)   rdata_o = ctrl_rd;
    if (sel_tim[0]) rdata_o = tim_rd[0];
    if (sel_tim[1]) rdata_o = tim_rd[1];
    if (sel_tim2)   rdata_o = tim2_q | TIM2_ONES;
    if (sel_stat)   rdata_o = stat_rd;
    if (sel_subp)   rdata_o = subp_q;
  end

  assign ctrl_o    = ctrl_q;
  assign width_o   = size_q[0];
  assign height_o  = size_q[1];
  assign en_rise_o = rise_q;
  assign en_fall_o = fall_q;

  p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.en) |-> en_rise_o);
  p_stop_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.en) |-> en_fall_o);
  p_width_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_tim[0]) |=> (width_o != '0));
  p_status_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_stat) |=> ($stable(ctrl_q) && $stable(tim2_q) && $stable(subp_q)));
endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIM_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              pal_done_i,
  input  logic              frame_done_i,
  input  logic              sync_err_i,
  output logic              en_o,
  output logic              en_rise_o,
  output logic              en_fall_o,
  output logic [1:0]        mode_o,
  output logic              tft_o,
  output logic              mono_o,
  output logic [DIM_W:0]    width_o,
  output logic [DIM_W:0]    height_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  stat_t stat;
  logic  en_set, en_clr, frame_on_stop;

  dispctl_cfg #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_cfg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_i            (wr_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .stat_i          (stat),
    .rdata_o         (rdata_o),
    .ctrl_o          (ctrl),
    .width_o         (width_o),
    .height_o        (height_o),
    .en_set_o        (en_set),
    .en_clr_o        (en_clr),
    .frame_on_stop_o (frame_on_stop),
    .en_rise_o       (en_rise_o),
    .en_fall_o       (en_fall_o)
  );

  dispctl_stat u_stat (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pal_ev_i        (pal_done_i),
    .frame_ev_i      (frame_done_i),
    .sync_ev_i       (sync_err_i),
    .en_set_i        (en_set),
    .en_clr_i        (en_clr),
    .frame_on_stop_i (frame_on_stop),
    .ie_i            (ctrl.ie),
    .stat_o          (stat),
    .irq_o           (irq_o)
  );

  assign en_o   = ctrl.en;
  assign mode_o = ctrl.mode;
  assign tft_o  = ctrl.tft;
  assign mono_o = ctrl.mono;

  p_rst_irq_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
  p_pulse_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_rise_o && en_fall_o));
endmodule

// File: tb/dispctl_regs_test.sv
module dispctl_regs_test;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DIM_W  = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              pal_done_i = 1'b0, frame_done_i = 1'b0, sync_err_i = 1'b0;
  logic              en_o, en_rise_o, en_fall_o, tft_o, mono_o, irq_o;
  logic [1:0]        mode_o;
  logic [DIM_W:0]    width_o, height_o;

  always #2.5 clk_i = ~clk_i;

  dispctl_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pal_done_i(pal_done_i), .frame_done_i(frame_done_i),
    .sync_err_i(sync_err_i), .en_o(en_o), .en_rise_o(en_rise_o), .en_fall_o(en_fall_o),
    .mode_o(mode_o), .tft_o(tft_o), .mono_o(mono_o), .width_o(width_o),
    .height_o(height_o), .irq_o(irq_o)
  );

  localparam int S_RD = 0, S_IRQ = 1, S_PULSE = 2, S_WID = 3, S_HGT = 4;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected control readback, built from R2
  function automatic logic [31:0] ctrl_model(logic [31:0] d);
    logic [31:0] r;
    r = 32'hFE00_0C34 | (d & 32'h01CF_F300) | (d & 32'h0030_009B);
    if (d[7]) r = r | 32'h0080_0000;
    return r;
  endfunction

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic expect_now(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    step();
    wr_i = 1'b0; addr_i = a;
    expect_now(S_RD, exp, tag);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [2:0] ev);
    step();
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    {pal_done_i, frame_done_i, sync_err_i} = ev;
    step();
    wr_i = 1'b0;
    {pal_done_i, frame_done_i, sync_err_i} = 3'b000;
  endtask

  task automatic ev(logic [2:0] e);
    step();
    {pal_done_i, frame_done_i, sync_err_i} = e;
    step();
    {pal_done_i, frame_done_i, sync_err_i} = 3'b000;
  endtask

  // monitor: pops expectations away from the active edge
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        S_RD:    act = rdata_o;
        S_IRQ:   act = {31'd0, irq_o};
        S_PULSE: act = {30'd0, en_rise_o, en_fall_o};
        S_WID:   act = 32'(width_o);
        default: act = 32'(height_o);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset values
    rd(8'h00, 32'hFE00_0C34, "R1 ctrl");
    rd(8'h04, 32'h0000_03FF, "R1 tim0");
    rd(8'h08, 32'h0000_03FF, "R1 tim1");
    rd(8'h0C, 32'hFC00_0000, "R1 tim2");
    rd(8'h10, 32'h0, "R1 status");
    rd(8'h14, 32'h0, "R1 subp");
    expect_now(S_IRQ, 0, "R1 irq");
    rd(8'h18, 32'h0, "R5 unmapped read");

    // R2 / R9 start, R8 stop with mode 3
    wr(8'h00, 32'hFFFF_FFFF, 3'b000);
    expect_now(S_PULSE, 32'h2, "R9 start pulse");
    rd(8'h00, ctrl_model(32'hFFFF_FFFF), "R2 ctrl all ones");
    rd(8'h10, 32'h0, "R9 status after start");
    wr(8'h00, 32'hFFFF_FFFE, 3'b000);
    expect_now(S_PULSE, 32'h1, "R8 stop pulse");
    step();
    expect_now(S_IRQ, 1, "R7 frame irq");
    rd(8'h10, 32'h1, "R8 frame set on stop");

    // load mode 1: start clears, stop leaves frame-done clear
    wr(8'h00, 32'h0010_0001, 3'b000);
    rd(8'h10, 32'h0, "R9 start clears frame");
    wr(8'h00, 32'h0010_0000, 3'b000);
    rd(8'h10, 32'h0, "R8 mode1 no frame");
    rd(8'h00, ctrl_model(32'h0010_0000), "R2 ctrl sparse");
    step();
    expect_now(S_IRQ, 0, "R7 irq low");

    // R3 sizes
    wr(8'h04, 32'hABCD_E123, 3'b000);
    rd(8'h04, 32'hABCD_E12F, "R3 tim0 read");
    expect_now(S_WID, 32'h124, "R3 width");
    wr(8'h04, 32'h0000_03FF, 3'b000);
    rd(8'h04, 32'h0000_03FF, "R3 tim0 max");
    expect_now(S_WID, 32'h400, "R3 width max");
    wr(8'h08, 32'h5555_5400, 3'b000);
    rd(8'h08, 32'h5555_5400, "R3 tim1 read");
    expect_now(S_HGT, 32'h1, "R3 height min");

    // R4
    wr(8'h0C, 32'h1234_5678, 3'b000);
    rd(8'h0C, 32'hFE34_5678, "R4 tim2");
    wr(8'h14, 32'hFFFF_FFFF, 3'b000);
    rd(8'h14, 32'hA1FF_FFFF, "R4 subp");

    // R6 / R5
    ev(3'b100);
    rd(8'h10, 32'h40, "R6 palette bit");
    expect_now(S_IRQ, 0, "R7 palette masked");
    wr(8'h10, 32'hFFFF_FFFF, 3'b000);
    rd(8'h10, 32'h40, "R5 status write ignored");
    wr(8'h18, 32'hFFFF_FFFF, 3'b000);
    rd(8'h18, 32'h0, "R5 unmapped write");
    rd(8'h00, ctrl_model(32'h0010_0000), "R5 ctrl untouched");
    rd(8'h0C, 32'hFE34_5678, "R5 tim2 untouched");

    // R7 enables
    wr(8'h00, 32'h0000_0010, 3'b000);
    expect_now(S_PULSE, 32'h0, "R9 no pulse without change");
    step();
    expect_now(S_IRQ, 1, "R7 palette irq");
    ev(3'b001);
    rd(8'h10, 32'h44, "R6 sync bit");
    wr(8'h00, 32'h0, 3'b000);
    step();
    expect_now(S_IRQ, 1, "R7 sync ignores enables");

    // R10 set beats clear
    wr(8'h00, 32'h1, 3'b010);
    rd(8'h10, 32'h05, "R10 frame kept on start");
    wr(8'h00, 32'h0, 3'b001);
    rd(8'h10, 32'h05, "R10 sync kept on stop");
    wr(8'h00, 32'h1, 3'b000);
    rd(8'h10, 32'h04, "R9 start keeps sync");
    wr(8'h00, 32'h0, 3'b000);
    rd(8'h10, 32'h01, "R8 stop clears sync");
    step();
    expect_now(S_IRQ, 0, "R7 irq cleared");

    repeat (3) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule